// File: doc/BRIEF.md
# Phase-Split Two-Read One-Write Register File

This block is the integer register file of a pipelined processor. Every operation cycle, it returns two source operands and accepts one result. The register storage has only one physically shared access path, made of two single-ended lines. Each operation cycle is therefore split into two ticks of a double-rate clock. In the first tick (the read half), the two lines serve as independent single-ended read paths, one for each read port. In the second tick (the write half), both lines carry the write data together, as a true/complement pair, into the selected register.

Because the reads come before the write inside a cycle, a read of the register being written returns the value it held before that cycle. If a caller wants the new value instead, it raises a bypass flag, which forwards the write data straight to the matching read port. Register 0 is hardwired to zero. A phase output tells the surrounding pipeline which half of the cycle the next clock edge serves. The read outputs are registered at the end of the read half and are held through the write half.

Top module: `tm_regfile`

## Requirements
- R1: While `rst` is high at a rising edge of `clk2x`, every register is cleared to zero, both read outputs go to zero and `phase` goes to 0; register reads issued after reset return zero until the register is written.
- R2: At the end of a read tick, `rd_data_a` takes the contents of register `rd_addr_a` and `rd_data_b` takes the contents of register `rd_addr_b`; the two addresses are independent and may be equal.
- R3: When a read and a write address the same nonzero register in one cycle and the bypass is not taken, the read returns the value the register held before that cycle, and the written value is returned by reads in later cycles.
- R4: Address 0 always reads as zero, and a write to address 0 changes no register.
- R5: When `bypass_en` and `wr_en` are both 1 and `wr_addr` equals a nonzero read address, that read port returns `wr_data` in the same cycle.
- R6: `phase` alternates on every `clk2x` edge after reset. `phase` = 0 marks that the next edge ends a read tick, and `phase` = 1 marks that it ends a write tick. A write with `wr_en` = 1 takes effect only at the end of a write tick, and `wr_en` = 0 leaves all registers unchanged.
- R7: Both read outputs stay unchanged across the edge that ends a write tick; they change only at the end of a read tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate clock; two rising edges make one operation cycle |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Read address, port A |
| rd_addr_b | input | 5 | Read address, port B |
| rd_data_a | output | 32 | Registered read data, port A |
| rd_data_b | output | 32 | Registered read data, port B |
| wr_en | input | 1 | Write enable for this cycle |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| bypass_en | input | 1 | Forward this cycle's write data to a matching read port |
| phase | output | 1 | 0: next edge ends the read tick; 1: next edge ends the write tick |

## Verification
The properties assume that the caller holds every address, data, enable and bypass input constant across both ticks of an operation cycle. The cycle boundary is taken from the `phase` output, so a value that changed halfway through a cycle would mix the read of one request with the write of another. The stimulus changes its inputs only on a falling edge at which `phase` is 0, so that each request occupies exactly one read tick and the write tick that follows it. The bench also asserts reset mid-run only between complete cycles.

// File: rtl/tmrf_pkg.sv
package tmrf_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int AW   = $clog2(NREG);

    typedef logic [AW-1:0]   addr_t;
    typedef logic [XLEN-1:0] word_t;

    typedef enum logic {
        PH_READ  = 1'b0,
        PH_WRITE = 1'b1
    } phase_e;

    // One single-ended line of the shared access path.
    typedef struct packed {
        addr_t addr;
        word_t line;
        logic  drive;
    } path_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
        word_t data;
    } wreq_t;

    function automatic logic fwd_hit(logic byp, wreq_t w, addr_t ra);
        return byp && w.en && (w.addr == ra) && (ra != '0);
    endfunction

endpackage

// File: rtl/tmrf_phase_gen.sv
module tmrf_phase_gen
    import tmrf_pkg::*;
(
    input  logic   clk2x,
    input  logic   rst,
    output phase_e phase
);

    always_ff @(posedge clk2x) begin
        if (rst) begin
            phase <= PH_READ;
        end else begin
            phase <= (phase == PH_READ) ? PH_WRITE : PH_READ;
        end
    end

endmodule

// File: rtl/tmrf_port_mux.sv
module tmrf_port_mux
    import tmrf_pkg::*;
(
    input  phase_e phase,
    input  addr_t  rd_addr_a,
    input  addr_t  rd_addr_b,
    input  wreq_t  wreq,
    output path_t  path_a,
    output path_t  path_b
);

    always_comb begin
        if (phase == PH_READ) begin
            // Two independent single-ended reads.
            path_a.addr  = rd_addr_a;
            path_a.line  = '0;
            path_a.drive = 1'b0;
            path_b.addr  = rd_addr_b;
            path_b.line  = '0;
            path_b.drive = 1'b0;
        end else begin
            // Both lines carry one differential write.
            path_a.addr  = wreq.addr;
            path_a.line  = wreq.data;
            path_a.drive = wreq.en && (wreq.addr != '0);
            path_b.addr  = wreq.addr;
            path_b.line  = ~wreq.data;
            path_b.drive = wreq.en && (wreq.addr != '0);
        end
    end

endmodule

// File: rtl/tmrf_storage.sv
module tmrf_storage
    import tmrf_pkg::*;
(
    input  logic  clk2x,
    input  logic  rst,
    input  path_t path_a,
    input  path_t path_b,
    output word_t sense_a,
    output word_t sense_b
);

    word_t rows [NREG];
    logic  diff_ok;

    // The cell flips only when the two lines really form a true/complement pair.
    assign diff_ok = path_a.drive && path_b.drive &&
                     (path_a.addr == path_b.addr) &&
                     (path_a.line == ~path_b.line);

    assign rows[0] = '0;

    for (genvar r = 1; r < NREG; r++) begin : g_row
        word_t q;
        logic  sel;
        assign sel = diff_ok && (path_a.addr == AW'(r));
        always_ff @(posedge clk2x) begin
            if (rst) begin
                q <= '0;
            end else if (sel) begin
                q <= path_a.line;
            end
        end
        assign rows[r] = q;
    end

    assign sense_a = rows[path_a.addr];
    assign sense_b = rows[path_b.addr];

endmodule

// File: rtl/tm_regfile.sv
module tm_regfile
    import tmrf_pkg::*;
(
    input  logic        clk2x,
    input  logic        rst,
    input  logic [4:0]  rd_addr_a,
    input  logic [4:0]  rd_addr_b,
    output logic [31:0] rd_data_a,
    output logic [31:0] rd_data_b,
    input  logic        wr_en,
    input  logic [4:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        bypass_en,
    output logic        phase
);

    phase_e ph;
    wreq_t  wreq;
    path_t  path_a;
    path_t  path_b;
    word_t  sense_a;
    word_t  sense_b;
    logic   fwd_a;
    logic   fwd_b;

    assign wreq = '{en: wr_en, addr: wr_addr, data: wr_data};

    tmrf_phase_gen u_phase (
        .clk2x (clk2x),
        .rst   (rst),
        .phase (ph)
    );

    tmrf_port_mux u_mux (
        .phase     (ph),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .wreq      (wreq),
        .path_a    (path_a),
        .path_b    (path_b)
    );

    tmrf_storage u_store (
        .clk2x   (clk2x),
        .rst     (rst),
        .path_a  (path_a),
        .path_b  (path_b),
        .sense_a (sense_a),
        .sense_b (sense_b)
    );

    assign fwd_a = fwd_hit(bypass_en, wreq, rd_addr_a);
    assign fwd_b = fwd_hit(bypass_en, wreq, rd_addr_b);

    always_ff @(posedge clk2x) begin
        if (rst) begin
            rd_data_a <= '0;
            rd_data_b <= '0;
        end else if (ph == PH_READ) begin
            rd_data_a <= fwd_a ? wr_data : sense_a;
            rd_data_b <= fwd_b ? wr_data : sense_b;
        end
    end

    assign phase = ph;

endmodule

// File: rtl/tm_regfile_chk.sv
module tm_regfile_chk
    import tmrf_pkg::*;
(
    input logic        clk2x,
    input logic        rst,
    input logic [4:0]  rd_addr_a,
    input logic [4:0]  rd_addr_b,
    input logic [31:0] rd_data_a,
    input logic [31:0] rd_data_b,
    input logic        wr_en,
    input logic [4:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        bypass_en,
    input logic        phase,
    input path_t       path_a,
    input path_t       path_b
);

    assert_reset_R1: assert property (@(posedge clk2x)
        $past(rst) |-> (rd_data_a == '0 && rd_data_b == '0 && phase == 1'b0));

    assert_phase_toggle_R6: assert property (@(posedge clk2x) disable iff (rst)
        !$past(rst) |-> (phase != $past(phase)));

    assert_diff_write_R6: assert property (@(posedge clk2x) disable iff (rst)
        (phase && path_a.drive) |-> (path_b.drive && path_a.addr == path_b.addr &&
                                     path_a.line == ~path_b.line));

    assert_hold_R7: assert property (@(posedge clk2x) disable iff (rst)
        phase |=> ($stable(rd_data_a) && $stable(rd_data_b)));

    assert_zero_a_R4: assert property (@(posedge clk2x) disable iff (rst)
        (!phase && rd_addr_a == 5'd0) |=> (rd_data_a == '0));

    assert_zero_b_R4: assert property (@(posedge clk2x) disable iff (rst)
        (!phase && rd_addr_b == 5'd0) |=> (rd_data_b == '0));

    assert_bypass_a_R5: assert property (@(posedge clk2x) disable iff (rst)
        (!phase && bypass_en && wr_en && wr_addr == rd_addr_a && rd_addr_a != 5'd0)
        |=> (rd_data_a == $past(wr_data)));

    assert_bypass_b_R5: assert property (@(posedge clk2x) disable iff (rst)
        (!phase && bypass_en && wr_en && wr_addr == rd_addr_b && rd_addr_b != 5'd0)
        |=> (rd_data_b == $past(wr_data)));

endmodule

bind tm_regfile tm_regfile_chk u_chk (
    .clk2x     (clk2x),
    .rst       (rst),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .bypass_en (bypass_en),
    .phase     (phase),
    .path_a    (path_a),
    .path_b    (path_b)
);

// File: tb/tm_regfile_bench.sv
module tm_regfile_bench;

    logic        clk2x = 1'b0;
    logic        rst;
    logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic [31:0] rd_data_a, rd_data_b, wr_data;
    logic        wr_en, bypass_en, phase;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #10 clk2x = ~clk2x;   // 50 MHz

    tm_regfile u_tm_regfile (
        .clk2x(clk2x), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bypass_en(bypass_en), .phase(phase)
    );

    // Behavioural reference model
    logic [31:0] ref_mem [32];
    logic [31:0] exp_a = 0, exp_b = 0;
    logic        exp_ph = 0;
    string       tag_a = "R1", tag_b = "R1";

    function automatic string pick_tag(logic [4:0] ra);
        if (ra == 0) return "R4";
        if (bypass_en && wr_en && wr_addr == ra) return "R5";
        if (wr_en && wr_addr == ra) return "R3";
        return "R2";
    endfunction

    always @(posedge clk2x) begin
        if (rst) begin
            foreach (ref_mem[i]) ref_mem[i] = 0;
            exp_a  <= 0;
            exp_b  <= 0;
            exp_ph <= 0;
            tag_a  <= "R1";
            tag_b  <= "R1";
        end else if (exp_ph == 0) begin
            exp_a <= (rd_addr_a == 0) ? 32'd0 :
                     (bypass_en && wr_en && wr_addr == rd_addr_a) ? wr_data : ref_mem[rd_addr_a];
            exp_b <= (rd_addr_b == 0) ? 32'd0 :
                     (bypass_en && wr_en && wr_addr == rd_addr_b) ? wr_data : ref_mem[rd_addr_b];
            tag_a  <= pick_tag(rd_addr_a);
            tag_b  <= pick_tag(rd_addr_b);
            exp_ph <= 1;
        end else begin
            if (wr_en && wr_addr != 0) ref_mem[wr_addr] = wr_data;
            tag_a  <= "R7";
            tag_b  <= "R7";
            exp_ph <= 0;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk2x) begin
        if (!finished) begin
            check(tag_a, rd_data_a, exp_a, "rd_data_a");
            check(tag_b, rd_data_b, exp_b, "rd_data_b");
            check("R6", {31'd0, phase}, {31'd0, exp_ph}, "phase");
        end
    end

    task automatic op(input logic [4:0] ra, input logic [4:0] rb, input logic we,
                      input logic [4:0] wa, input logic [31:0] wd, input logic byp);
        while (phase !== 1'b0) @(negedge clk2x);
        rd_addr_a = ra; rd_addr_b = rb;
        wr_en = we; wr_addr = wa; wr_data = wd; bypass_en = byp;
        @(negedge clk2x);
        @(negedge clk2x);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk2x);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        rd_addr_a = 0; rd_addr_b = 0; wr_en = 0; wr_addr = 0; wr_data = 0; bypass_en = 0;
        repeat (3) @(negedge clk2x);
        // R1: reset state
        check("R1", rd_data_a, 32'd0, "reset rd_data_a");
        check("R1", {31'd0, phase}, 32'd0, "reset phase");
        rst = 1'b0;
        @(negedge clk2x);
        // R1: fresh registers read zero
        op(5'd7, 5'd31, 1'b0, 5'd0, 32'd0, 1'b0);
        // R2: fill registers and read pairs
        for (int i = 1; i < 32; i++) op(5'd0, 5'd0, 1'b1, 5'(i), 32'hA500_0000 + 32'(i * 17), 1'b0);
        for (int i = 0; i < 32; i++) op(5'(i), 5'(31 - i), 1'b0, 5'd0, 32'd0, 1'b0);
        op(5'd9, 5'd9, 1'b0, 5'd0, 32'd0, 1'b0);
        // R4: write to register 0 is ignored, even with bypass
        op(5'd0, 5'd0, 1'b1, 5'd0, 32'hFFFF_FFFF, 1'b1);
        op(5'd0, 5'd1, 1'b0, 5'd0, 32'd0, 1'b0);
        // R3: same-cycle read of written register returns the old value
        op(5'd5, 5'd6, 1'b1, 5'd5, 32'h1234_5678, 1'b0);
        op(5'd5, 5'd5, 1'b0, 5'd0, 32'd0, 1'b0);
        // R5: bypass forwards the new value to both ports
        op(5'd6, 5'd6, 1'b1, 5'd6, 32'hDEAD_BEEF, 1'b1);
        // R5/R3: bypass with wr_en low does not forward; R6: register unchanged
        op(5'd6, 5'd7, 1'b0, 5'd6, 32'h0BAD_0BAD, 1'b1);
        op(5'd6, 5'd7, 1'b0, 5'd0, 32'd0, 1'b0);
        // Mixed traffic
        for (int n = 0; n < 400; n++)
            op(5'($urandom), 5'($urandom), 1'($urandom), 5'($urandom), $urandom, 1'($urandom));
        // R1: reset mid-run clears all registers
        do_reset();
        @(negedge clk2x);
        for (int i = 0; i < 32; i += 2) op(5'(i), 5'(i + 1), 1'b0, 5'd0, 32'd0, 1'b0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule